// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block decides when a debug session reaches its trigger point. It watches event pulses from a set of address/data comparators and walks a five-state machine (Disarmed, State1, State2, State3, Final). In each of the three active states, every comparator has its own programmable destination. When the machine arrives in Final, it pulses a trace-start strobe for the capture logic. If breakpoints are enabled, it also raises a breakpoint request toward the CPU, and that request stays up until the CPU acknowledges it.

Each comparator is timed in one of two ways. A tagged comparator acts when the CPU reports that the marked opcode has reached execution. A forced comparator's match is parked in a single pending slot and acts at the next instruction boundary. Software arms, disarms and triggers the sequencer through a two-bit write port. Bit 0 is the arm bit. Bit 1 is an immediate trigger that jumps straight to Final. The breakpoint flavour, either software-interrupt execution or debug-mode entry, is captured on entry to Final.

Top module: `dbg_trig_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer goes to Disarmed (`seqState` = 0) with `traceStart`, `brkReq` and `brkType` all 0. The state encoding is 0 Disarmed, 1 State1, 2 State2, 3 State3, 4 Final.
- R2: A write with `wrArm`=0 sends the sequencer to Disarmed from any state. It also drops `brkReq` and empties the pending slot. A write with `wrArm`=1 and `wrTrig`=0 moves Disarmed to State1 and has no effect on any other state.
- R3: In State1..3, an event from comparator c moves the state to the 3-bit code at `cfgNext[((s-1)*NUM_CMP+c)*3 +: 3]`, where s is the current state. Codes 1..4 name the destination. Codes 0 and 5..7 mean that the event is ignored.
- R4: For a comparator with its `cfgTagged` bit set, the event is its `tagHit` pulse, and the state changes at that same clock edge. Its `cmpMatch` is ignored.
- R5: For a comparator with its `cfgTagged` bit clear, a `cmpMatch` is held pending and acts at the first `instrBoundary` in a later cycle. A boundary in the match cycle does not fire it. The `tagHit` of such a comparator is ignored.
- R6: There is one pending slot. While it is full, further matches are ignored. If several forced matches arrive together, the lowest index is kept. Matches that arrive outside State1..3 are not captured.
- R7: When several events arrive in the same cycle, the lowest-index comparator decides the transition.
- R8: A write with `wrArm`=1 and `wrTrig`=1 moves the sequencer to Final from any state. A trigger with `wrArm`=0 only disarms.
- R9: `traceStart` is high for exactly the first cycle in Final and does not repeat while the sequencer stays in Final.
- R10: On entry to Final with `cfgBrkEn`=1, `brkReq` rises and stays high until `brkAck`. If entry and acknowledge fall in the same cycle, the request still rises. `brkType` latches `cfgBrkSwi` at entry (1 = software interrupt, 0 = debug-mode entry).
- R11: Final is kept, with all comparator events ignored, until a disarm write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWr | input | 1 | Write strobe of the arm/trigger register |
| wrArm | input | 1 | Written arm bit |
| wrTrig | input | 1 | Written immediate-trigger bit |
| cmpMatch | input | NUM_CMP | Comparator match pulses |
| tagHit | input | NUM_CMP | Tagged opcode of comparator c reached execution |
| instrBoundary | input | 1 | Instruction boundary strobe |
| cfgTagged | input | NUM_CMP | 1 = tagged timing, 0 = forced timing, per comparator |
| cfgNext | input | 9*NUM_CMP | Next-state codes, 3 bits per (active state, comparator) |
| cfgBrkEn | input | 1 | Raise a breakpoint request on entry to Final |
| cfgBrkSwi | input | 1 | Breakpoint type to latch: 1 software interrupt, 0 debug mode |
| brkAck | input | 1 | CPU acknowledge of the breakpoint request |
| seqState | output | 3 | Current sequencer state |
| traceStart | output | 1 | One-cycle trace start pulse |
| brkReq | output | 1 | Breakpoint request level |
| brkType | output | 1 | Latched breakpoint type |

## Verification
The bench exercises the timing split between the two kinds of comparator. It sends a forced match together with a boundary in the same cycle: a design that fires early would change state one cycle too soon. It also sends tag hits to forced comparators and matches to tagged ones, where a design that mixed the two up would take a wrong branch. The bench fills the pending slot and then sends a second match, and it sends two matches in one cycle. A design that overwrote the slot, or preferred the higher index, would land in Final or State1 instead of the expected state. It also checks that a disarm leaves no stale pending event behind, that a second trigger while already in Final gives no new trace pulse, and that an acknowledge in the entry cycle does not swallow the request.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  localparam int STATE_W = 3;
  localparam int ACTIVE_STATES = 3;

  typedef enum logic [STATE_W-1:0] {
    SEQ_OFF   = 3'd0,
    SEQ_S1    = 3'd1,
    SEQ_S2    = 3'd2,
    SEQ_S3    = 3'd3,
    SEQ_FINAL = 3'd4
  } seqState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic enterFinal;
    logic clearAll;
    logic captureEn;
  } seqStrobe_t;

endpackage

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbg_seq_pkg::*;
#(
  parameter int NUM_CMP = 4,
  localparam int IDX_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
  localparam int CFG_W = ACTIVE_STATES * NUM_CMP * STATE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             regWr,
  input  logic             wrArm,
  input  logic             wrTrig,
  input  logic             evtValid,
  input  logic [IDX_W-1:0] evtIdx,
  input  logic [CFG_W-1:0] cfgNext,
  output seqState_e        seqState,
  output seqStrobe_t       strobe
);

  seqState_e stateQ, stateD;
  logic inActive;
  logic [STATE_W-1:0] code;
  logic codeOk;
  int rowSel;

  always_comb begin
    inActive = (stateQ == SEQ_S1) || (stateQ == SEQ_S2) || (stateQ == SEQ_S3);
    rowSel   = inActive ? (int'(stateQ) - 1) : 0;
    code     = cfgNext[(rowSel * NUM_CMP + int'(evtIdx)) * STATE_W +: STATE_W];
    codeOk   = (code >= 3'd1) && (code <= 3'd4);

    stateD = stateQ;
    if (regWr && !wrArm)                        stateD = SEQ_OFF;
    else if (regWr && wrTrig)                   stateD = SEQ_FINAL;
    else if (regWr && stateQ == SEQ_OFF)        stateD = SEQ_S1;
    else if (inActive && evtValid && codeOk)    stateD = seqState_e'(code);

    strobe.clearAll   = regWr && !wrArm;
    strobe.enterFinal = (stateD == SEQ_FINAL) && (stateQ != SEQ_FINAL);
    strobe.captureEn  = inActive;
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= SEQ_OFF;
    else     stateQ <= stateD;
  end

  assign seqState = stateQ;

endmodule

// File: rtl/dbg_seq_dp.sv
module dbg_seq_dp
  import dbg_seq_pkg::*;
#(
  parameter int NUM_CMP = 4,
  localparam int IDX_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  seqStrobe_t         strobe,
  input  logic [NUM_CMP-1:0] cmpMatch,
  input  logic [NUM_CMP-1:0] tagHit,
  input  logic               instrBoundary,
  input  logic [NUM_CMP-1:0] cfgTagged,
  input  logic               cfgBrkEn,
  input  logic               cfgBrkSwi,
  input  logic               brkAck,
  output logic               evtValid,
  output logic [IDX_W-1:0]   evtIdx,
  output logic               traceStart,
  output logic               brkReq,
  output logic               brkType
);

  function automatic logic [IDX_W:0] firstSet(input logic [NUM_CMP-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = NUM_CMP - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, IDX_W'(i)};
    return r;
  endfunction

  logic               pendValid;
  logic [IDX_W-1:0]   pendIdx;
  logic [NUM_CMP-1:0] fireVec, evtVec, forcedMatch;
  logic               capValid;
  logic [IDX_W-1:0]   capIdx;

  assign forcedMatch = cmpMatch & ~cfgTagged;

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_fire
    assign fireVec[c] = pendValid && instrBoundary && (pendIdx == IDX_W'(c));
  end

  assign evtVec = (tagHit & cfgTagged) | fireVec;
  assign {evtValid, evtIdx} = firstSet(evtVec);
  assign {capValid, capIdx} = firstSet(forcedMatch);

  // single pending slot for forced comparators
  always_ff @(posedge clk) begin
    if (rst || strobe.clearAll) begin
      pendValid <= 1'b0;
      pendIdx   <= '0;
    end else if (pendValid && instrBoundary) begin
      pendValid <= 1'b0;
    end else if (!pendValid && strobe.captureEn && capValid) begin
      pendValid <= 1'b1;
      pendIdx   <= capIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      traceStart <= 1'b0;
      brkReq     <= 1'b0;
      brkType    <= 1'b0;
    end else begin
      traceStart <= strobe.enterFinal;
      if (strobe.clearAll)                     brkReq <= 1'b0;
      else if (strobe.enterFinal && cfgBrkEn)  brkReq <= 1'b1;
      else if (brkAck)                         brkReq <= 1'b0;
      if (strobe.enterFinal) brkType <= cfgBrkSwi;
    end
  end

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_seq_pkg::*;
#(
  parameter int NUM_CMP = 4,
  localparam int IDX_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
  localparam int CFG_W = ACTIVE_STATES * NUM_CMP * STATE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               regWr,
  input  logic               wrArm,
  input  logic               wrTrig,
  input  logic [NUM_CMP-1:0] cmpMatch,
  input  logic [NUM_CMP-1:0] tagHit,
  input  logic               instrBoundary,
  input  logic [NUM_CMP-1:0] cfgTagged,
  input  logic [CFG_W-1:0]   cfgNext,
  input  logic               cfgBrkEn,
  input  logic               cfgBrkSwi,
  input  logic               brkAck,
  output logic [STATE_W-1:0] seqState,
  output logic               traceStart,
  output logic               brkReq,
  output logic               brkType
);

  seqStrobe_t       strobe;
  seqState_e        stateNow;
  logic             evtValid;
  logic [IDX_W-1:0] evtIdx;

  dbg_seq_ctrl #(.NUM_CMP(NUM_CMP)) u_ctrl (
    .clk(clk), .rst(rst), .regWr(regWr), .wrArm(wrArm), .wrTrig(wrTrig),
    .evtValid(evtValid), .evtIdx(evtIdx), .cfgNext(cfgNext),
    .seqState(stateNow), .strobe(strobe)
  );

  dbg_seq_dp #(.NUM_CMP(NUM_CMP)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .cmpMatch(cmpMatch), .tagHit(tagHit),
    .instrBoundary(instrBoundary), .cfgTagged(cfgTagged), .cfgBrkEn(cfgBrkEn),
    .cfgBrkSwi(cfgBrkSwi), .brkAck(brkAck), .evtValid(evtValid), .evtIdx(evtIdx),
    .traceStart(traceStart), .brkReq(brkReq), .brkType(brkType)
  );

  assign seqState = stateNow;

endmodule

// File: rtl/dbg_trig_seq_chk.sv
module dbg_trig_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       regWr,
  input logic       wrArm,
  input logic       wrTrig,
  input logic       brkAck,
  input logic [2:0] seqState,
  input logic       traceStart,
  input logic       brkReq
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (seqState == 3'd0) && !brkReq && !traceStart);

  // R2
  disarm_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (regWr && !wrArm) |=> (seqState == 3'd0) && !brkReq && !traceStart);

  // R8
  trig_to_final_chk: assert property (@(posedge clk) disable iff (rst)
    (regWr && wrArm && wrTrig) |=> (seqState == 3'd4));

  // R9
  trace_in_final_chk: assert property (@(posedge clk) disable iff (rst)
    traceStart |-> (seqState == 3'd4));

  // R9
  trace_single_chk: assert property (@(posedge clk) disable iff (rst)
    traceStart |=> !traceStart);

  // R10
  brk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (brkReq && !brkAck && !(regWr && !wrArm)) |=> brkReq);

  // R10
  brk_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(brkReq) |-> traceStart);

  // R11
  final_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((seqState == 3'd4) && !(regWr && !wrArm)) |=> (seqState == 3'd4));

endmodule

bind dbg_trig_seq dbg_trig_seq_chk u_chk (
  .clk(clk), .rst(rst), .regWr(regWr), .wrArm(wrArm), .wrTrig(wrTrig),
  .brkAck(brkAck), .seqState(seqState), .traceStart(traceStart), .brkReq(brkReq)
);

// File: tb/dbg_trig_seq_tb.sv
`timescale 1ns/1ps
module dbg_trig_seq_tb;

  localparam int NC = 4;
  localparam int NV = 39;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, regWr, wrArm, wrTrig, instrBoundary, cfgBrkEn, cfgBrkSwi, brkAck;
  logic [NC-1:0] cmpMatch, tagHit, cfgTagged;
  logic [3*NC*3-1:0] cfgNext;
  logic [2:0] seqState;
  logic traceStart, brkReq, brkType;

  int nRun = 0;
  int nFail = 0;

  dbg_trig_seq #(.NUM_CMP(NC)) u_dut (
    .clk(clk), .rst(rst), .regWr(regWr), .wrArm(wrArm), .wrTrig(wrTrig),
    .cmpMatch(cmpMatch), .tagHit(tagHit), .instrBoundary(instrBoundary),
    .cfgTagged(cfgTagged), .cfgNext(cfgNext), .cfgBrkEn(cfgBrkEn),
    .cfgBrkSwi(cfgBrkSwi), .brkAck(brkAck), .seqState(seqState),
    .traceStart(traceStart), .brkReq(brkReq), .brkType(brkType)
  );

  // {req, wr, arm, trig, match[3:0], tag[3:0], bnd, ack, expState, expTrace, expBrk}
  localparam logic [21:0] VEC [NV] = '{
    {4'd1,  18'b0_0_0_0000_0000_0_0_000_0_0}, // R1 idle
    {4'd6,  18'b0_0_0_1000_0000_0_0_000_0_0}, // R6 match while disarmed
    {4'd6,  18'b0_0_0_0000_0000_1_0_000_0_0}, // R6 nothing was captured
    {4'd2,  18'b1_1_0_0000_0000_0_0_001_0_0}, // R2 arm
    {4'd5,  18'b0_0_0_0001_0000_0_0_001_0_0}, // R5 c0 pending
    {4'd6,  18'b0_0_0_1000_0000_0_0_001_0_0}, // R6 second match dropped
    {4'd5,  18'b0_0_0_0000_0000_1_0_010_0_0}, // R5 fires c0 -> S2
    {4'd5,  18'b0_0_0_0000_0000_1_0_010_0_0}, // R5 empty slot
    {4'd3,  18'b0_0_0_0000_0100_0_0_010_0_0}, // R3 code 0 ignored
    {4'd4,  18'b0_0_0_0100_0000_1_0_010_0_0}, // R4 match of tagged comparator
    {4'd4,  18'b0_0_0_0000_0000_1_0_010_0_0}, // R4 not pending
    {4'd5,  18'b0_0_0_0010_0000_0_0_010_0_0}, // R5 c1 pending
    {4'd3,  18'b0_0_0_0000_0000_1_0_011_0_0}, // R3 S2 c1 -> S3
    {4'd5,  18'b0_0_0_0000_0001_0_0_011_0_0}, // R5 tag of forced comparator
    {4'd6,  18'b0_0_0_0011_0000_0_0_011_0_0}, // R6 two matches, c0 kept
    {4'd9,  18'b0_0_0_0000_0000_1_0_100_1_1}, // R9 S3 c0 -> Final
    {4'd9,  18'b0_0_0_0000_0000_0_0_100_0_1}, // R9 pulse over
    {4'd11, 18'b0_0_0_0000_0100_0_1_100_0_0}, // R11 R10 ack, event ignored
    {4'd9,  18'b1_1_1_0000_0000_0_0_100_0_0}, // R9 re-trigger in Final
    {4'd2,  18'b1_0_0_0000_0000_0_0_000_0_0}, // R2 disarm
    {4'd2,  18'b1_1_0_0000_0000_0_0_001_0_0}, // R2 arm
    {4'd8,  18'b1_1_1_0000_0000_0_0_100_1_1}, // R8 software trigger
    {4'd2,  18'b1_0_0_0000_0000_0_0_000_0_0}, // R2 disarm drops request
    {4'd2,  18'b1_1_0_0000_0000_0_0_001_0_0}, // R2 arm
    {4'd4,  18'b0_0_0_0000_0100_0_0_011_0_0}, // R4 tag c2 -> S3
    {4'd3,  18'b0_0_0_0000_0100_0_0_011_0_0}, // R3 S3 c2 ignored
    {4'd8,  18'b1_0_1_0000_0000_0_0_000_0_0}, // R8 trig without arm
    {4'd2,  18'b1_1_0_0000_0000_0_0_001_0_0}, // R2 arm
    {4'd5,  18'b0_0_0_1000_0000_0_0_001_0_0}, // R5 c3 pending
    {4'd2,  18'b1_0_0_0000_0000_0_0_000_0_0}, // R2 disarm
    {4'd2,  18'b1_1_0_0000_0000_0_0_001_0_0}, // R2 arm
    {4'd2,  18'b0_0_0_0000_0000_1_0_001_0_0}, // R2 slot was emptied
    {4'd5,  18'b0_0_0_1000_0000_1_0_001_0_0}, // R5 same-cycle boundary
    {4'd5,  18'b0_0_0_0000_0000_1_0_100_1_1}, // R5 fires next boundary
    {4'd10, 18'b0_0_0_0000_0000_0_1_100_0_0}, // R10 ack
    {4'd2,  18'b1_0_0_0000_0000_0_0_000_0_0}, // R2 disarm
    {4'd2,  18'b1_1_0_0000_0000_0_0_001_0_0}, // R2 arm
    {4'd5,  18'b0_0_0_0001_0000_0_0_001_0_0}, // R5 c0 pending
    {4'd7,  18'b0_0_0_0000_0100_1_0_010_0_0}  // R7 c0 beats tag c2
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic a, input logic t, input logic [3:0] m,
                       input logic [3:0] g, input logic b, input logic k);
    @(negedge clk);
    regWr = w; wrArm = a; wrTrig = t; cmpMatch = m; tagHit = g;
    instrBoundary = b; brkAck = k;
    @(posedge clk);
    #5;
  endtask

  task automatic setNext(input int s, input int c, input logic [2:0] code);
    cfgNext[((s - 1) * NC + c) * 3 +: 3] = code;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [21:0] v;
    rst = 1'b1; regWr = 0; wrArm = 0; wrTrig = 0; cmpMatch = '0; tagHit = '0;
    instrBoundary = 0; brkAck = 0; cfgBrkEn = 1; cfgBrkSwi = 1;
    cfgTagged = 4'b0100;
    cfgNext = '0;
    setNext(1, 0, 3'd2); setNext(1, 1, 3'd0); setNext(1, 2, 3'd3); setNext(1, 3, 3'd4);
    setNext(2, 0, 3'd0); setNext(2, 1, 3'd3); setNext(2, 2, 3'd0); setNext(2, 3, 3'd1);
    setNext(3, 0, 3'd4); setNext(3, 1, 3'd1); setNext(3, 2, 3'd0); setNext(3, 3, 3'd0);
    repeat (3) @(posedge clk);
    #5;
    check("R1", "state", int'(seqState), 0);
    check("R1", "brkReq", int'(brkReq), 0);
    check("R1", "traceStart", int'(traceStart), 0);
    check("R1", "brkType", int'(brkType), 0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      drive(v[17], v[16], v[15], v[14:11], v[10:7], v[6], v[5]);
      check($sformatf("R%0d row %0d", v[21:18], i), "state", int'(seqState), int'(v[4:2]));
      check($sformatf("R%0d row %0d", v[21:18], i), "traceStart", int'(traceStart), int'(v[1]));
      check($sformatf("R%0d row %0d", v[21:18], i), "brkReq", int'(brkReq), int'(v[0]));
    end

    // R10 type latched as software interrupt
    drive(1, 1, 1, 4'b0, 4'b0, 0, 0);
    check("R10", "brkType swi", int'(brkType), 1);

    // R1 reset from Final
    @(negedge clk);
    regWr = 0; wrArm = 0; wrTrig = 0; rst = 1'b1;
    @(posedge clk);
    #5;
    check("R1", "state after reset", int'(seqState), 0);
    check("R1", "brkReq after reset", int'(brkReq), 0);
    check("R1", "brkType after reset", int'(brkType), 0);
    @(negedge clk) rst = 1'b0;

    // R10 debug-mode type
    cfgBrkSwi = 1'b0;
    drive(1, 1, 0, 4'b0, 4'b0, 0, 0);
    drive(1, 1, 1, 4'b0, 4'b0, 0, 0);
    check("R10", "brkType debug", int'(brkType), 0);
    check("R10", "brkReq debug", int'(brkReq), 1);
    drive(1, 0, 0, 4'b0, 4'b0, 0, 0);

    // R10 breakpoints disabled: trace only
    cfgBrkEn = 1'b0;
    drive(1, 1, 0, 4'b0, 4'b0, 0, 0);
    drive(1, 1, 1, 4'b0, 4'b0, 0, 0);
    check("R10", "trace without brk", int'(traceStart), 1);
    check("R10", "no brk when disabled", int'(brkReq), 0);
    drive(1, 0, 0, 4'b0, 4'b0, 0, 0);
    cfgBrkEn = 1'b1;

    // R10 ack in the entry cycle does not cancel the request
    drive(1, 1, 0, 4'b0, 4'b0, 0, 0);
    drive(1, 1, 1, 4'b0, 4'b0, 0, 1);
    check("R10", "set wins over ack", int'(brkReq), 1);
    drive(0, 0, 0, 4'b0, 4'b0, 0, 0);
    check("R10", "request held", int'(brkReq), 1);
    drive(0, 0, 0, 4'b0, 4'b0, 0, 1);
    check("R10", "request cleared by ack", int'(brkReq), 0);
    check("R11", "still Final", int'(seqState), 4);

    drive(0, 0, 0, 4'b0, 4'b0, 0, 0);
    finishRun();
  end

endmodule